// File: doc/BRIEF.md
# Mask-Protected Control Register Bank

This block holds a bank of control words, each carrying sixteen control bits, and drives every stored bit onto one flat output vector for the logic around it. Software reaches a word through a word index on a single-cycle write or read strobe. A write word is split in two: its upper half is a per-bit enable and its lower half holds the new values. Only the bits whose enable is set change. Any subset of bits, or a multi-bit field, can therefore be set or cleared in one write, with no read-modify-write and no risk of disturbing a neighbouring field that another agent owns.

To set bit n, software writes (1<<(n+16))|(1<<n). To clear bit n, it writes 1<<(n+16) alone. A field of width w at offset b is written as ((ones(w)<<16)|value)<<b. The word index is the bus byte address with its two low bits dropped, so word i sits at byte address i*4. Reads are registered and return the stored bits with a zero upper half.

Top module: `mask_ctrl_bank`

## Requirements
- R1: While rst_n is low and after it rises, every control bit is 0 and rdata is 0.
- R2: On a write (wr_en high at a rising edge) to an existing word, each bit n whose enable bit wdata[n+16] is 1 takes the value wdata[n]. The new value is visible on ctrl_bits after that edge.
- R3: A bit whose enable bit is 0 keeps its value, and no word other than the addressed one changes.
- R4: A write whose enable half wdata[31:16] is all zero leaves every control bit unchanged.
- R5: Flat output bit k is bit k%16 of word k/16, and word i is selected by waddr == i (byte address i*4). At most one word is written per cycle.
- R6: A field of width w at offset b is updated by one write of ((2^w-1)<<16 | value)<<b. Bits outside the field stay as they were.
- R7: A read (rd_en high at a rising edge) loads rdata after that edge with {16'h0, word bits}. rdata keeps its value until the next read.
- R8: A write with waddr >= NUM_WORDS changes no control bit.
- R9: A read with waddr >= NUM_WORDS loads rdata with 0.
- R10: A read and a write in the same cycle (they share waddr) return the word's contents from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| waddr | input | WADDR_W | Word index (byte address divided by 4) |
| wdata | input | 32 | Write word: [31:16] bit enables, [15:0] values |
| rdata | output | 32 | Registered read data, upper half zero |
| ctrl_bits | output | NUM_WORDS*16 | All control bits, word i at [16*i+15:16*i] |

## Verification
A read and a masked write can hit the same word at the same edge, because both strobes share one word index. The bench raises both strobes together on a word that already holds a known pattern and writes a pattern that changes some bits. It expects rdata to show the old pattern and ctrl_bits to show the merged new one in the same sampling window. Random traffic also raises both strobes together often, including on indices outside the bank, where the read must return zero and the write must do nothing.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  localparam int unsigned CTRL_W = 16;
  localparam int unsigned BUS_W  = 32;

  // Combine stored bits with a write word: upper half enables, lower half values.
  function automatic logic [CTRL_W-1:0] merge_masked(
    input logic [CTRL_W-1:0] old_bits,
    input logic [BUS_W-1:0]  wr_word
  );
    logic [CTRL_W-1:0] en;
    logic [CTRL_W-1:0] val;
    en  = wr_word[BUS_W-1:CTRL_W];
    val = wr_word[CTRL_W-1:0];
    return (old_bits & ~en) | (val & en);
  endfunction

  // Shape stored bits as a bus word for the read path.
  function automatic logic [BUS_W-1:0] to_bus_word(input logic [CTRL_W-1:0] bits);
    return {{(BUS_W-CTRL_W){1'b0}}, bits};
  endfunction

endpackage

// File: rtl/mcb_decode.sv
module mcb_decode #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WADDR_W   = 4
) (
  input  logic [WADDR_W-1:0]   waddr,
  output logic [NUM_WORDS-1:0] word_sel,
  output logic                 addr_hit
);

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign word_sel[i] = (waddr == WADDR_W'(i));
  end

  assign addr_hit = |word_sel;

endmodule

// File: rtl/mcb_word.sv
module mcb_word
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BUS_W-1:0]  wr_word,
  output logic [CTRL_W-1:0] bits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else if (we) begin
      bits <= merge_masked(bits, wr_word);
    end
  end

endmodule

// File: rtl/mcb_rdport.sv
module mcb_rdport
  import mcb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned FLAT_W   = NUM_WORDS * CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [NUM_WORDS-1:0] word_sel,
  input  logic [FLAT_W-1:0]    words,
  output logic [BUS_W-1:0]     rdata
);

  logic [CTRL_W-1:0] picked;

  // AND-OR select: an index outside the bank has no select and reads zero.
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (word_sel[i]) begin
        picked = picked | words[i*CTRL_W +: CTRL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= to_bus_word(picked);
    end
  end

endmodule

// File: rtl/mask_ctrl_bank.sv
module mask_ctrl_bank
  import mcb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WADDR_W   = 4,
  localparam int unsigned FLAT_W   = NUM_WORDS * CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  output logic [FLAT_W-1:0]  ctrl_bits
);

  logic [NUM_WORDS-1:0] word_sel;
  logic                 addr_hit;
  logic [NUM_WORDS-1:0] wr_strobe;

  mcb_decode #(
    .NUM_WORDS (NUM_WORDS),
    .WADDR_W   (WADDR_W)
  ) u_decode (
    .waddr    (waddr),
    .word_sel (word_sel),
    .addr_hit (addr_hit)
  );

  assign wr_strobe = word_sel & {NUM_WORDS{wr_en}};

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    mcb_word u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_strobe[w]),
      .wr_word (wdata),
      .bits    (ctrl_bits[w*CTRL_W +: CTRL_W])
    );
  end

  mcb_rdport #(
    .NUM_WORDS (NUM_WORDS)
  ) u_rdport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .word_sel (word_sel),
    .words    (ctrl_bits),
    .rdata    (rdata)
  );

endmodule

// File: rtl/mcb_chk.sv
module mcb_chk
  import mcb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WADDR_W   = 4,
  localparam int unsigned FLAT_W   = NUM_WORDS * CTRL_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [WADDR_W-1:0]   waddr,
  input logic [BUS_W-1:0]     wdata,
  input logic [BUS_W-1:0]     rdata,
  input logic [FLAT_W-1:0]    ctrl_bits,
  input logic [NUM_WORDS-1:0] wr_strobe,
  input logic                 addr_hit
);

  logic [FLAT_W-1:0] en_flat;
  logic [FLAT_W-1:0] val_flat;

  // Spread the write word across the flat vector, independent of the decoder.
  always_comb begin
    en_flat  = '0;
    val_flat = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (wr_en && (32'(waddr) == i)) begin
        en_flat[i*CTRL_W +: CTRL_W]  = wdata[BUS_W-1:CTRL_W];
        val_flat[i*CTRL_W +: CTRL_W] = wdata[CTRL_W-1:0];
      end
    end
  end

  // R2
  enabled_bits_take_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_bits ^ $past(val_flat)) & $past(en_flat)) == '0);

  // R3
  disabled_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_bits ^ $past(ctrl_bits)) & ~$past(en_flat)) == '0);

  // R4
  zero_enable_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[BUS_W-1:CTRL_W] == '0) |=> $stable(ctrl_bits));

  // R5
  single_word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));

  // R7
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:CTRL_W] == '0);

  // R7
  rdata_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R8
  outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_hit) |=> $stable(ctrl_bits));

  // R9
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr_hit) |=> rdata == '0);

endmodule

bind mask_ctrl_bank mcb_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WADDR_W   (WADDR_W)
) u_mcb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .waddr     (waddr),
  .wdata     (wdata),
  .rdata     (rdata),
  .ctrl_bits (ctrl_bits),
  .wr_strobe (wr_strobe),
  .addr_hit  (addr_hit)
);

// File: tb/tb_mask_ctrl_bank.sv
module tb_mask_ctrl_bank;

  localparam int unsigned NW  = 8;
  localparam int unsigned AW  = 4;
  localparam int unsigned FW  = NW * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [FW-1:0] ctrl_bits;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] model [NW];
  logic [31:0] exp_rd;

  always #2.5 clk = ~clk;

  mask_ctrl_bank #(.NUM_WORDS(NW), .WADDR_W(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .waddr     (waddr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ctrl_bits (ctrl_bits)
  );

  function automatic logic [FW-1:0] model_flat();
    logic [FW-1:0] f;
    for (int k = 0; k < FW; k++) f[k] = model[k / 16][k % 16];
    return f;
  endfunction

  // Bit-by-bit restatement of the masked update.
  function automatic logic [15:0] bitwise_update(input logic [15:0] old, input logic [31:0] d);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) r[n] = d[n + 16] ? d[n] : old[n];
    return r;
  endfunction

  task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic step(input logic wr, input logic rd, input logic [AW-1:0] a,
                      input logic [31:0] d, input string tag);
    int idx;
    idx = int'(a);
    wr_en = wr; rd_en = rd; waddr = a; wdata = d;
    if (rd) exp_rd = (idx < NW) ? {16'h0, model[idx]} : 32'h0;
    if (wr && idx < NW) model[idx] = bitwise_update(model[idx], d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check({tag, " ctrl"}, ctrl_bits, model_flat());
    check({tag, " rdata"}, FW'(rdata), FW'(exp_rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) model[i] = 16'h0;
    exp_rd = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset
    check("R1 ctrl in reset", ctrl_bits, '0);
    check("R1 rdata in reset", FW'(rdata), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl after reset", ctrl_bits, '0);

    // R2: set bit 3 of word 0, then clear it
    step(1'b1, 1'b0, 4'd0, (32'h1 << 19) | 32'h8, "R2 set bit3");
    check("R2 flat bit 3", FW'(ctrl_bits[3]), FW'(1'b1));
    step(1'b1, 1'b0, 4'd1, 32'hFFFF_A5C3, "R2 full word");
    step(1'b1, 1'b0, 4'd1, 32'h1 << 16, "R2 clear bit0");
    check("R2 word1", FW'(ctrl_bits[31:16]), FW'(16'hA5C2));

    // R4: zero enable half with busy value half
    step(1'b1, 1'b0, 4'd1, 32'h0000_FFFF, "R4 zero enables");
    check("R4 word1 kept", FW'(ctrl_bits[31:16]), FW'(16'hA5C2));

    // R6: field width 4 at offset 5 in word 2, value 0xA
    step(1'b1, 1'b0, 4'd2, 32'hFFFF_FFFF, "R6 preset");
    step(1'b1, 1'b0, 4'd2, ((32'hF << 16) | 32'hA) << 5, "R6 field");
    check("R6 word2", FW'(ctrl_bits[47:32]), FW'(16'hFF5F));

    // R5: flat index 37 is word 2 bit 5; word 7 at top of vector
    step(1'b1, 1'b0, 4'd2, (32'h1 << 21), "R5 clear k37");
    check("R5 flat k37", FW'(ctrl_bits[37]), FW'(1'b0));
    step(1'b1, 1'b0, 4'd7, 32'h8000_8000, "R5 top bit");
    check("R5 flat k127", FW'(ctrl_bits[127]), FW'(1'b1));

    // R7: read word 1, then hold without a read
    step(1'b0, 1'b1, 4'd1, 32'h0, "R7 read word1");
    check("R7 rdata word1", FW'(rdata), FW'(32'h0000_A5C2));
    step(1'b1, 1'b0, 4'd1, 32'hFFFF_0000, "R7 hold");
    check("R7 rdata held", FW'(rdata), FW'(32'h0000_A5C2));

    // R8: write outside the bank
    step(1'b1, 1'b0, 4'd8, 32'hFFFF_FFFF, "R8 outside write");
    step(1'b1, 1'b0, 4'd15, 32'hFFFF_FFFF, "R8 last index");
    // R9: outside read after a nonzero read
    step(1'b0, 1'b1, 4'd7, 32'h0, "R9 prior read");
    step(1'b0, 1'b1, 4'd12, 32'h0, "R9 outside read");
    check("R9 rdata zero", FW'(rdata), '0);

    // R10: read and write same word in one cycle
    step(1'b1, 1'b0, 4'd0, 32'h00FF_0055, "R10 preset");
    step(1'b1, 1'b1, 4'd0, 32'h00FF_00AA, "R10 same cycle");
    check("R10 old value read", FW'(rdata), FW'(32'h0000_0055));
    check("R10 new value stored", FW'(ctrl_bits[15:0]), FW'(16'h00AA));

    // R3 R7 R8 R9 R10: random mixed traffic
    for (int it = 0; it < 400; it++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 8) == 0) d[31:16] = 16'h0;
      step(1'($urandom % 2), 1'($urandom % 2), AW'($urandom % 12), d, "R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule